// File: doc/BRIEF.md
# Line-Synchronous Integration Period Controller

This block decides where each energy integration period ends so that every period spans a whole number of mains cycles and lasts about one second. It sees a sample strobe at a fixed, known rate and three signed, narrow-band filtered phase voltages. It counts rising zero-crossings of one chosen phase and measures time in strobe ticks. At the end of each period it emits a one-cycle pulse together with the number of cycles and the number of ticks the period covered.

The reference phase is either fixed to A, B or C, or picked automatically as the enabled phase that showed the largest peak magnitude over the previous period. A mode bit selects between two closing rules. In one rule the period length is the cycle count that lands nearest to one second. In the other it is the largest cycle count that does not exceed one second. If the reference phase stops crossing, a timeout closes the period with a cycle count of zero and a flag set.

Top module: `line_sync_period_ctrl`

## Requirements
- R1: A crossing is recognised only in a cycle where `smp_stb` is 1, and only when the sample taken at the previous strobe was negative (sign bit set) and the current sample is zero or positive. Time is measured in strobes, and clock cycles without a strobe do not count.
- R2: `sync_sel` encoding: 0 means the dynamically chosen dominant phase, 1 means phase A (`v_a`), 2 means phase B (`v_b`) and 3 means phase C (`v_c`).
- R3: With `limit_mode` = 0, the period closes on a counted crossing when the ticks since the period start, plus half (rounded down) of the cycle length just measured, reach `TICKS_PER_SEC` or more.
- R4: With `limit_mode` = 1, the period closes on a counted crossing when the ticks since the period start, plus the cycle length just measured, exceed `TICKS_PER_SEC`.
- R5: `phase_en` bit 0 enables A, bit 1 enables B and bit 2 enables C. Crossings of a disabled phase are never counted, and a disabled phase is never chosen as dominant.
- R6: In dynamic mode the phase used is latched at each period end. It becomes the enabled phase with the largest peak absolute sample seen during the period that just ended; a tie goes to the earlier letter. After reset the phase is A. When no phase is enabled, the previous choice is kept.
- R7: When 2*`TICKS_PER_SEC` ticks pass with no counted crossing, a period end is signalled with `timeout_flag` = 1, `cycle_count` = 0 and `period_ticks` equal to the ticks elapsed. The block then waits for a new starting crossing.
- R8: `period_end` is a single-cycle pulse, one clock after the deciding strobe. `cycle_count`, `period_ticks` and `timeout_flag` change only with that pulse and hold between pulses. All outputs are 0 after reset.
- R9: After reset or a timeout, the first counted crossing starts a period without counting as a cycle. Each later period starts on the crossing that closed the previous one, and `period_ticks` counts the strobes from the starting crossing to the closing crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | Sample strobe, one tick per assertion |
| v_a | input | SAMPLE_W | Filtered phase A voltage, signed |
| v_b | input | SAMPLE_W | Filtered phase B voltage, signed |
| v_c | input | SAMPLE_W | Filtered phase C voltage, signed |
| phase_en | input | 3 | Phase enables, bit 0 = A, 1 = B, 2 = C |
| sync_sel | input | 2 | Reference phase select (0 dynamic, 1 A, 2 B, 3 C) |
| limit_mode | input | 1 | 0 = nearest to one second, 1 = never over one second |
| period_end | output | 1 | One-cycle pulse at each period end |
| cycle_count | output | CYC_W | Whole cycles in the ended period (0 on timeout) |
| period_ticks | output | TICK_W | Strobe ticks in the ended period |
| timeout_flag | output | 1 | Set when the ended period closed by timeout |

## Verification
The hardest situation to reach is the dynamic hand-over. The reference phase changes at a period end, and the next period then starts on a crossing of the old phase but counts crossings of the new one. The first cycle of that period is therefore a short, partial one. The bench reaches this state from reset by giving phase A and phase B different line periods and amplitudes, with a still larger phase C that is disabled. The exact cycle and tick counts of the first three periods then confirm the hand-over, the partial first cycle and the exclusion of the disabled phase. Separate runs hold the inputs at a negative value between strobes, to show that only strobed samples matter, and silence the reference phase to force timeouts.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
   localparam int NUM_PH = 3;
   typedef enum logic [1:0] {PH_A = 2'd0, PH_B = 2'd1, PH_C = 2'd2} phase_e;
endpackage

// File: rtl/lsp_zc_detect.sv
module lsp_zc_detect #(
   parameter int SAMPLE_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       stb,
   input  logic signed [SAMPLE_W-1:0] sample,
   output logic                       rise
);
   logic prev_neg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev_neg <= 1'b0;
      else if (stb) prev_neg <= sample[SAMPLE_W-1];
   end

   assign rise = stb && prev_neg && !sample[SAMPLE_W-1];
endmodule

// File: rtl/lsp_peak_track.sv
module lsp_peak_track #(
   parameter int SAMPLE_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       stb,
   input  logic                       clear,
   input  logic signed [SAMPLE_W-1:0] sample,
   output logic        [SAMPLE_W-1:0] peak
);
   logic [SAMPLE_W-1:0] mag;

   assign mag = sample[SAMPLE_W-1] ? SAMPLE_W'(-sample) : SAMPLE_W'(sample);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  peak <= '0;
      else if (clear)              peak <= '0;
      else if (stb && mag > peak)  peak <= mag;
   end
endmodule

// File: rtl/lsp_dom_select.sv
module lsp_dom_select
   import lsp_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 latch,
   input  logic [NUM_PH-1:0]                    en,
   input  logic [NUM_PH-1:0][SAMPLE_W-1:0]      peaks,
   output logic [1:0]                           dom
);
   logic [1:0]          best;
   logic [SAMPLE_W-1:0] best_v;
   logic                found;

   always_comb begin
      best   = dom;
      best_v = '0;
      found  = 1'b0;
      for (int i = 0; i < NUM_PH; i++) begin
         if (en[i] && (!found || peaks[i] > best_v)) begin
            best   = 2'(i);
            best_v = peaks[i];
            found  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dom <= PH_A;
      else if (latch)  dom <= best;
   end

   assert_dom_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && |en) |=> en[dom]);
endmodule

// File: rtl/line_sync_period_ctrl.sv
module line_sync_period_ctrl
   import lsp_pkg::*;
#(
   parameter int SAMPLE_W      = 16,
   parameter int TICKS_PER_SEC = 400,
   parameter int CYC_W         = $clog2(TICKS_PER_SEC + 1),
   parameter int TICK_W        = $clog2(4 * TICKS_PER_SEC)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_stb,
   input  logic signed [SAMPLE_W-1:0] v_a,
   input  logic signed [SAMPLE_W-1:0] v_b,
   input  logic signed [SAMPLE_W-1:0] v_c,
   input  logic [2:0]                 phase_en,
   input  logic [1:0]                 sync_sel,
   input  logic                       limit_mode,
   output logic                       period_end,
   output logic [CYC_W-1:0]           cycle_count,
   output logic [TICK_W-1:0]          period_ticks,
   output logic                       timeout_flag
);
   localparam int               SUM_W  = TICK_W + 1;
   localparam logic [SUM_W-1:0] ONE_S  = SUM_W'(TICKS_PER_SEC);
   localparam logic [TICK_W-1:0] TO_LIM = TICK_W'(2 * TICKS_PER_SEC);

   if (SAMPLE_W < 2)              begin : g_bad_w  $error("SAMPLE_W too small");      end
   if (TICKS_PER_SEC < 4)         begin : g_bad_t  $error("TICKS_PER_SEC too small"); end
   if ((1 << CYC_W) <= TICKS_PER_SEC / 2) begin : g_bad_c $error("CYC_W too narrow"); end
   if ((1 << TICK_W) <= 3 * TICKS_PER_SEC) begin : g_bad_k $error("TICK_W too narrow"); end

   logic signed [SAMPLE_W-1:0]        smp [NUM_PH];
   logic [NUM_PH-1:0]                 rise;
   logic [NUM_PH-1:0][SAMPLE_W-1:0]   peak;
   logic                              close_evt;
   logic [1:0]                        dom;

   assign smp[PH_A] = v_a;
   assign smp[PH_B] = v_b;
   assign smp[PH_C] = v_c;

   for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
      lsp_zc_detect #(.SAMPLE_W(SAMPLE_W)) u_zc (
         .clk(clk), .rst_n(rst_n), .stb(smp_stb), .sample(smp[g]), .rise(rise[g]));
      lsp_peak_track #(.SAMPLE_W(SAMPLE_W)) u_pk (
         .clk(clk), .rst_n(rst_n), .stb(smp_stb), .clear(close_evt),
         .sample(smp[g]), .peak(peak[g]));
   end

   lsp_dom_select #(.SAMPLE_W(SAMPLE_W)) u_dom (
      .clk(clk), .rst_n(rst_n), .latch(close_evt), .en(phase_en),
      .peaks(peak), .dom(dom));

   // reference phase and its qualified crossing
   logic [1:0] sel_ph;
   logic [3:0] rise_all, en_all;
   logic       zc_hit;

   assign sel_ph   = (sync_sel == 2'd0) ? dom : (sync_sel - 2'd1);
   assign rise_all = {1'b0, rise};
   assign en_all   = {1'b0, phase_en};
   assign zc_hit   = rise_all[sel_ph] && en_all[sel_ph];

   // period timing state
   logic              armed;
   logic [TICK_W-1:0] elapsed, since_zc, el_nx, sn_nx;
   logic [CYC_W-1:0]  cycles, cyc_nx;
   logic [SUM_W-1:0]  sum_full, sum_half;
   logic              close_ok, timeout_hit;

   assign el_nx    = elapsed + 1'b1;
   assign sn_nx    = since_zc + 1'b1;
   assign cyc_nx   = cycles + 1'b1;
   assign sum_full = {1'b0, el_nx} + {1'b0, sn_nx};
   assign sum_half = {1'b0, el_nx} + {2'b0, sn_nx[TICK_W-1:1]};

   assign close_ok    = armed && zc_hit &&
                        (limit_mode ? (sum_full > ONE_S) : (sum_half >= ONE_S));
   assign timeout_hit = smp_stb && !zc_hit && (sn_nx == TO_LIM);
   assign close_evt   = close_ok || timeout_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed        <= 1'b0;
         elapsed      <= '0;
         since_zc     <= '0;
         cycles       <= '0;
         period_end   <= 1'b0;
         cycle_count  <= '0;
         period_ticks <= '0;
         timeout_flag <= 1'b0;
      end else begin
         period_end <= 1'b0;
         if (timeout_hit) begin
            period_end   <= 1'b1;
            cycle_count  <= '0;
            period_ticks <= el_nx;
            timeout_flag <= 1'b1;
            armed        <= 1'b0;
            elapsed      <= '0;
            since_zc     <= '0;
            cycles       <= '0;
         end else if (zc_hit) begin
            since_zc <= '0;
            if (!armed) begin
               armed   <= 1'b1;
               elapsed <= '0;
               cycles  <= '0;
            end else if (close_ok) begin
               period_end   <= 1'b1;
               cycle_count  <= cyc_nx;
               period_ticks <= el_nx;
               timeout_flag <= 1'b0;
               elapsed      <= '0;
               cycles       <= '0;
            end else begin
               elapsed <= el_nx;
               cycles  <= cyc_nx;
            end
         end else if (smp_stb) begin
            elapsed  <= el_nx;
            since_zc <= sn_nx;
         end
      end
   end

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> !period_end);
   assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end |-> ($stable(cycle_count) && $stable(period_ticks) && $stable(timeout_flag)));
   assert_end_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(period_end) |-> $past(smp_stb));
   assert_timeout_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && timeout_flag) |-> (cycle_count == '0));
   assert_counted_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && !timeout_flag) |-> (cycle_count != '0));
   assert_never_over_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && !timeout_flag && $past(limit_mode)) |->
         (period_ticks <= TICK_W'(TICKS_PER_SEC)));
endmodule

// File: tb/line_sync_period_ctrl_tb.sv
module line_sync_period_ctrl_tb;
   localparam int W = 16;
   localparam int T = 400;
   localparam int CW = $clog2(T + 1);
   localparam int KW = $clog2(4 * T);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_stb = 1'b0;
   logic signed [W-1:0] v_a = '0, v_b = '0, v_c = '0;
   logic [2:0] phase_en = 3'b111;
   logic [1:0] sync_sel = 2'd1;
   logic limit_mode = 1'b0;
   logic period_end, timeout_flag;
   logic [CW-1:0] cycle_count;
   logic [KW-1:0] period_ticks;

   always #5 clk = ~clk;

   line_sync_period_ctrl #(.SAMPLE_W(W), .TICKS_PER_SEC(T)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .v_a(v_a), .v_b(v_b), .v_c(v_c),
      .phase_en(phase_en), .sync_sel(sync_sel), .limit_mode(limit_mode),
      .period_end(period_end), .cycle_count(cycle_count),
      .period_ticks(period_ticks), .timeout_flag(timeout_flag));

   typedef struct { int cnt; int ticks; bit to; string req; } exp_t;
   exp_t exp_q[$];
   int checks = 0, errors = 0;
   bit done = 1'b0;
   bit prev_pe = 1'b0;
   exp_t last;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // monitor: pops expected items on every period end
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_pe) check(!period_end, "R8", "pulse width", period_end, 0);
         if (period_end) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected period end", 1, 0);
            end else begin
               last = exp_q.pop_front();
               check(cycle_count == CW'(last.cnt), last.req, "cycle_count", cycle_count, last.cnt);
               check(period_ticks == KW'(last.ticks), last.req, "period_ticks", period_ticks, last.ticks);
               check(timeout_flag == last.to, last.req, "timeout_flag", timeout_flag, last.to);
            end
         end
         prev_pe <= period_end;
      end
   end

   function automatic logic signed [W-1:0] wave(input int s, input int len, input int amp);
      if (amp == 0) return '0;
      return ((s % len) < len / 2) ? W'(amp) : W'(-amp);
   endfunction

   task automatic push(input int n, input int cnt, input int ticks, input bit to, input string req);
      exp_t e;
      e.cnt = cnt; e.ticks = ticks; e.to = to; e.req = req;
      for (int i = 0; i < n; i++) exp_q.push_back(e);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; smp_stb = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      prev_pe = 1'b0;
   endtask

   // drive nstb strobes; gap idle cycles between them with inputs held negative
   task automatic run(input int la, input int aa, input int lb, input int ab,
                      input int lc, input int ac, input int nstb, input int gap);
      for (int s = 0; s < nstb; s++) begin
         @(negedge clk);
         v_a = wave(s, la, aa); v_b = wave(s, lb, ab); v_c = wave(s, lc, ac);
         smp_stb = 1'b1;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            smp_stb = 1'b0;
            v_a = -1; v_b = -1; v_c = -1;
         end
      end
      @(negedge clk);
      smp_stb = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic scen_end(input string req);
      check(exp_q.size() == 0, req, "missing period ends", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      do_reset();
      @(negedge clk);
      check(period_end == 1'b0, "R8", "reset period_end", period_end, 0);
      check(cycle_count == '0, "R8", "reset cycle_count", cycle_count, 0);
      check(period_ticks == '0, "R8", "reset period_ticks", period_ticks, 0);
      check(timeout_flag == 1'b0, "R8", "reset timeout_flag", timeout_flag, 0);

      // R3: 30-tick cycles, closest rule -> 13 cycles, 390 ticks (R9 start crossing not counted)
      phase_en = 3'b001; sync_sel = 2'd1; limit_mode = 1'b0;
      push(3, 13, 390, 1'b0, "R3");
      run(30, 100, 30, 0, 30, 0, 1300, 0);
      scen_end("R3");
      check(cycle_count == 13 && period_ticks == 390, "R8", "held after last pulse",
            period_ticks, 390);

      // R3: 27-tick cycles -> 15 cycles, 405 ticks (over one second is allowed)
      do_reset();
      push(3, 15, 405, 1'b0, "R3");
      run(27, 100, 27, 0, 27, 0, 1300, 0);
      scen_end("R3");

      // R4: 27-tick cycles, never-over rule -> 14 cycles, 378 ticks
      do_reset();
      limit_mode = 1'b1;
      push(3, 14, 378, 1'b0, "R4");
      run(27, 100, 27, 0, 27, 0, 1300, 0);
      scen_end("R4");

      // R1/R2: phase B selected, strobe every 3rd clock, negative values between strobes
      do_reset();
      phase_en = 3'b010; sync_sel = 2'd2;
      push(2, 14, 378, 1'b0, "R1");
      run(27, 0, 27, 100, 27, 0, 900, 2);
      scen_end("R1");

      // R6/R5: dynamic; A first (30 ticks), then B (27 ticks, larger); C larger still but disabled
      do_reset();
      phase_en = 3'b011; sync_sel = 2'd0; limit_mode = 1'b0;
      push(1, 13, 390, 1'b0, "R6");
      push(1, 15, 390, 1'b0, "R6");
      push(1, 15, 405, 1'b0, "R6");
      run(30, 100, 27, 1000, 25, 5000, 1300, 0);
      scen_end("R6");

      // R7: no crossing at all -> timeout every 800 ticks with zero count
      do_reset();
      phase_en = 3'b111; sync_sel = 2'd1;
      push(2, 0, 800, 1'b1, "R7");
      run(30, 0, 30, 0, 30, 0, 1700, 0);
      scen_end("R7");

      // R5: static select of disabled phase C -> its crossings ignored, timeouts
      do_reset();
      phase_en = 3'b011; sync_sel = 2'd3;
      push(2, 0, 800, 1'b1, "R5");
      run(30, 100, 30, 100, 25, 500, 1700, 0);
      scen_end("R5");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule